// File: doc/BRIEF.md
# Vector Bitwise Logic Execute Unit

This unit accepts one 32-bit instruction word per cycle when a valid strobe is high. It recognises the three-register vector logical group and carries out the instruction against a local file of 32 vector registers, each 128 bits wide. Every operation in the group is an AND or an OR. The second operand can be inverted first, which gives four operations: plain AND, bit clear (AND with the complement), OR, and OR with the complement. A width bit in the word chooses between a 64-bit and a 128-bit datapath.

The result is registered when the word is accepted and is written to the destination register on the next clock. The latency never depends on the operand values. A forwarding path lets an instruction issued directly after another read the result that has not yet been written. A combinational flag pair reports whether a presented word matched the group. A debug read port and a debug write port give test access to the register file.

Top module: `vlu_top`

## Requirements
- R1: While `instValid` is high, `issueHit` is 1 exactly when bit 31 = 0, bits 29:24 = 001110, bit 21 = 1 and bits 15:10 = 000111. In that word, bit 30 is the width bit, bits 23:22 are the op field, bits 20:16 are the second-source index, bits 9:5 are the first-source index and bits 4:0 are the destination index.
- R2: A valid word that does not match raises `issueMiss` and changes no register.
- R3: The op field selects the operation. Bit 22 set inverts the second source before the operation. Bit 23 selects OR when 1 and AND when 0. So 00 gives AND, 01 gives bit clear (first AND NOT second), 10 gives OR and 11 gives OR-NOT.
- R4: With the width bit at 1, all 128 bits of the result follow R3.
- R5: With the width bit at 0, only bits 63:0 of the sources are used, and bits 127:64 of the destination are written as zero.
- R6: A word accepted at clock edge k updates its destination at edge k+1 and not before. The timing is the same for every operand value.
- R7: An instruction accepted at the edge right after another reads that earlier result through forwarding, for either source.
- R8: When the destination and sources share an index, the sources are read before the destination is written.
- R9: A synchronous active-high `rst` clears all 32 registers to zero.
- R10: A high `dbgWrEn` writes `dbgWrData` into register `dbgWrIdx`. `dbgRdData` always shows register `dbgRdIdx`. If a debug write and an instruction writeback hit the same register at the same edge, the writeback value is kept.
- R11: While `instValid` is low, both flags are 0 and no register changes, even if `instWord` matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | Instruction word is presented this cycle |
| instWord | input | 32 | Instruction word |
| issueHit | output | 1 | Valid word matches the logical group |
| issueMiss | output | 1 | Valid word does not match |
| dbgWrEn | input | 1 | Debug register write enable |
| dbgWrIdx | input | 5 | Debug write register index |
| dbgWrData | input | 128 | Debug write data |
| dbgRdIdx | input | 5 | Debug read register index |
| dbgRdData | output | 128 | Contents of the register selected by dbgRdIdx |

## Verification
Two events can land on the register file at the same edge: a debug write and the writeback of an instruction accepted one cycle earlier. The bench provokes this by issuing an instruction and then raising `dbgWrEn` in the next cycle. It does this once with the same target register, where it expects the writeback value to win, and once with different registers, where it expects both values to land. A second overlap is also covered: a new instruction is accepted while the previous result is still pending. The bench judges this by comparing against results it computes itself from the forwarded operand.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  // Register index width is fixed by the 5-bit index fields of the word.
  localparam int REG_IDX_W = 5;
  localparam int WORD_W    = 32;

  typedef struct packed {
    logic                 issue;   // accepted, matching instruction
    logic                 invert;  // complement second source
    logic                 useOr;   // OR instead of AND
    logic                 wide;    // full-width datapath
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rm;
  } ctrlStrobes_t;
endpackage

// File: rtl/vlu_ctrl.sv
module vlu_ctrl
  import vlu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord,
  output logic              issueHit,
  output logic              issueMiss,
  output ctrlStrobes_t      strobes
);
  logic fixedMatch;
  logic topOk, classOk, midOk, minorOk;

  // Fixed-bit fields of the group
  assign topOk      = (instWord[31] == 1'b0);
  assign classOk    = (instWord[29:24] == 6'b001110);
  assign midOk      = (instWord[21] == 1'b1);
  assign minorOk    = (instWord[15:10] == 6'b000111);
  assign fixedMatch = topOk && classOk && midOk && minorOk;

  assign issueHit   = instValid && fixedMatch;
  assign issueMiss  = instValid && !fixedMatch;

  always_comb begin
    strobes        = '0;
    strobes.issue  = issueHit;
    strobes.wide   = instWord[30];
    strobes.useOr  = instWord[23];
    strobes.invert = instWord[22];
    strobes.rm     = instWord[20:16];
    strobes.rn     = instWord[9:5];
    strobes.rd     = instWord[4:0];
  end

  AST_MISS_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (instValid && !(instWord[21] && !instWord[31])) |-> !strobes.issue); // R2
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!strobes.issue && !issueMiss)); // R11
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(issueHit && issueMiss)); // R1
endmodule

// File: rtl/vlu_regfile.sv
module vlu_regfile
  import vlu_pkg::*;
#(
  parameter int DATA_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [REG_IDX_W-1:0] rdIdxA,
  output logic [DATA_W-1:0]    rdDataA,
  input  logic [REG_IDX_W-1:0] rdIdxB,
  output logic [DATA_W-1:0]    rdDataB,
  input  logic [REG_IDX_W-1:0] rdIdxDbg,
  output logic [DATA_W-1:0]    rdDataDbg,
  input  logic                 wbEn,
  input  logic [REG_IDX_W-1:0] wbIdx,
  input  logic [DATA_W-1:0]    wbData,
  input  logic                 dbgEn,
  input  logic [REG_IDX_W-1:0] dbgIdx,
  input  logic [DATA_W-1:0]    dbgData
);
  localparam int NUM_REGS = 1 << REG_IDX_W;

  logic [DATA_W-1:0] mem [NUM_REGS];

  assign rdDataA   = mem[rdIdxA];
  assign rdDataB   = mem[rdIdxB];
  assign rdDataDbg = mem[rdIdxDbg];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else begin
      if (dbgEn) mem[dbgIdx] <= dbgData;
      // Writeback is applied last so it wins a same-index collision
      if (wbEn)  mem[wbIdx]  <= wbData;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (mem[0] == '0 && mem[NUM_REGS-1] == '0)); // R9
  AST_WB_LANDS: assert property (@(posedge clk) disable iff (rst)
    wbEn |=> (mem[$past(wbIdx)] == $past(wbData))); // R10
  AST_DBG_LANDS: assert property (@(posedge clk) disable iff (rst)
    (dbgEn && !(wbEn && wbIdx == dbgIdx)) |=> (mem[$past(dbgIdx)] == $past(dbgData))); // R10
endmodule

// File: rtl/vlu_dp.sv
module vlu_dp
  import vlu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strobes,
  input  logic                 dbgWrEn,
  input  logic [REG_IDX_W-1:0] dbgWrIdx,
  input  logic [DATA_W-1:0]    dbgWrData,
  input  logic [REG_IDX_W-1:0] dbgRdIdx,
  output logic [DATA_W-1:0]    dbgRdData
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int HALF_LANES = NUM_LANES / 2;

  logic [DATA_W-1:0]    rawA, rawB, opA, opB, result;
  logic                 wbValid, wbWide;
  logic [REG_IDX_W-1:0] wbIdx;
  logic [DATA_W-1:0]    wbData;

  vlu_regfile #(.DATA_W(DATA_W)) uRegs (
    .clk      (clk),
    .rst      (rst),
    .rdIdxA   (strobes.rn),
    .rdDataA  (rawA),
    .rdIdxB   (strobes.rm),
    .rdDataB  (rawB),
    .rdIdxDbg (dbgRdIdx),
    .rdDataDbg(dbgRdData),
    .wbEn     (wbValid),
    .wbIdx    (wbIdx),
    .wbData   (wbData),
    .dbgEn    (dbgWrEn),
    .dbgIdx   (dbgWrIdx),
    .dbgData  (dbgWrData)
  );

  // Forward a pending writeback to either source
  assign opA = (wbValid && wbIdx == strobes.rn) ? wbData : rawA;
  assign opB = (wbValid && wbIdx == strobes.rm) ? wbData : rawB;

  // Byte lanes: the upper half is forced to zero on the narrow datapath
  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : gLane
    logic [LANE_W-1:0] a, b, bSel, r;
    assign a    = opA[lane*LANE_W +: LANE_W];
    assign b    = opB[lane*LANE_W +: LANE_W];
    assign bSel = strobes.invert ? ~b : b;
    assign r    = strobes.useOr ? (a | bSel) : (a & bSel);
    if (lane >= HALF_LANES) begin : gUpper
      assign result[lane*LANE_W +: LANE_W] = strobes.wide ? r : '0;
    end else begin : gLower
      assign result[lane*LANE_W +: LANE_W] = r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbValid <= 1'b0;
      wbWide  <= 1'b0;
      wbIdx   <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strobes.issue;
      if (strobes.issue) begin
        wbWide <= strobes.wide;
        wbIdx  <= strobes.rd;
        wbData <= result;
      end
    end
  end

  AST_ONE_CYCLE_WB: assert property (@(posedge clk) disable iff (rst)
    strobes.issue |=> (wbValid && wbIdx == $past(strobes.rd))); // R6
  AST_NO_SPURIOUS_WB: assert property (@(posedge clk) disable iff (rst)
    !strobes.issue |=> !wbValid); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wbValid && !wbWide) |-> (wbData[DATA_W-1:DATA_W/2] == '0)); // R5
  AST_FWD_SRC_A: assert property (@(posedge clk) disable iff (rst)
    (strobes.issue && $past(strobes.issue) && strobes.rn == $past(strobes.rd))
      |-> (opA == wbData)); // R7
endmodule

// File: rtl/vlu_top.sv
module vlu_top
  import vlu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instValid,
  input  logic [WORD_W-1:0]    instWord,
  output logic                 issueHit,
  output logic                 issueMiss,
  input  logic                 dbgWrEn,
  input  logic [REG_IDX_W-1:0] dbgWrIdx,
  input  logic [DATA_W-1:0]    dbgWrData,
  input  logic [REG_IDX_W-1:0] dbgRdIdx,
  output logic [DATA_W-1:0]    dbgRdData
);
  ctrlStrobes_t strobes;

  vlu_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .instValid(instValid),
    .instWord (instWord),
    .issueHit (issueHit),
    .issueMiss(issueMiss),
    .strobes  (strobes)
  );

  vlu_dp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dbgWrEn  (dbgWrEn),
    .dbgWrIdx (dbgWrIdx),
    .dbgWrData(dbgWrData),
    .dbgRdIdx (dbgRdIdx),
    .dbgRdData(dbgRdData)
  );
endmodule

// File: tb/sim_vlu_top.sv
`timescale 1ns/1ps
module sim_vlu_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         instValid;
  logic [31:0]  instWord;
  logic         issueHit, issueMiss;
  logic         dbgWrEn;
  logic [4:0]   dbgWrIdx, dbgRdIdx;
  logic [127:0] dbgWrData, dbgRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vlu_top u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .issueHit(issueHit), .issueMiss(issueMiss),
    .dbgWrEn(dbgWrEn), .dbgWrIdx(dbgWrIdx), .dbgWrData(dbgWrData),
    .dbgRdIdx(dbgRdIdx), .dbgRdData(dbgRdData)
  );

  localparam logic [127:0] PA = 128'hF0F0_1234_5678_9ABC_DEF0_0FF0_A5A5_C33C;
  localparam logic [127:0] PB = 128'h0FF0_FFFF_0000_AAAA_5555_F00F_3C3C_8118;

  function automatic logic [31:0] mkWord(input logic q, input logic [1:0] op,
                                         input logic [4:0] rm, rn, rd);
    return {1'b0, q, 6'b001110, op, 1'b1, rm, 6'b000111, rn, rd};
  endfunction

  function automatic logic [127:0] model(input logic q, input logic [1:0] op,
                                         input logic [127:0] a, b);
    logic [127:0] bb, r;
    bb = op[0] ? ~b : b;
    r  = op[1] ? (a | bb) : (a & bb);
    if (!q) r[127:64] = '0;
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dbgWrite(input logic [4:0] idx, input logic [127:0] d);
    @(negedge clk);
    dbgWrEn = 1; dbgWrIdx = idx; dbgWrData = d;
    @(negedge clk);
    dbgWrEn = 0;
  endtask

  task automatic dbgRead(input logic [4:0] idx, output logic [127:0] d);
    dbgRdIdx = idx;
    #1;
    d = dbgRdData;
  endtask

  // Presents a word at a negedge; returns at the negedge after acceptance
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instValid = 1; instWord = w;
    @(negedge clk);
    instValid = 0;
  endtask

  task automatic testReset();
    logic [127:0] d;
    dbgWrite(5'd3, PA);
    dbgWrite(5'd31, PB);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 32; i++) begin
      dbgRead(i[4:0], d);
      check("R9 register clear", d, '0);
    end
  endtask

  task automatic testOps();
    logic [127:0] d;
    dbgWrite(5'd1, PA);
    dbgWrite(5'd2, PB);
    for (int q = 0; q < 2; q++) begin
      for (int op = 0; op < 4; op++) begin
        issue(mkWord(q[0], op[1:0], 5'd2, 5'd1, 5'd10));
        @(negedge clk);
        dbgRead(5'd10, d);
        // op 01 is bit clear; R3 covers all four, R4 wide, R5 narrow
        if (q == 1) check("R3 R4 wide op", d, model(1'b1, op[1:0], PA, PB));
        else        check("R3 R5 narrow op", d, model(1'b0, op[1:0], PA, PB));
      end
    end
  endtask

  task automatic testDecode();
    logic [127:0] d;
    logic [31:0]  good, bad;
    good = mkWord(1'b1, 2'b01, 5'd2, 5'd1, 5'd12);
    dbgWrite(5'd12, PB);
    @(negedge clk);
    instValid = 1; instWord = good; #1;
    check("R1 hit on match", {127'd0, issueHit}, 128'd1);
    check("R1 no miss on match", {127'd0, issueMiss}, 128'd0);
    instValid = 0;
    for (int k = 0; k < 4; k++) begin
      bad = good;
      case (k)
        0: bad[31] = 1'b1;
        1: bad[27] = 1'b0;
        2: bad[21] = 1'b0;
        default: bad[12] = 1'b0;
      endcase
      @(negedge clk);
      instValid = 1; instWord = bad; #1;
      check("R2 miss flag", {126'd0, issueHit, issueMiss}, 128'd1);
      @(negedge clk);
      instValid = 0;
      @(negedge clk);
      dbgRead(5'd12, d);
      check("R2 miss leaves register", d, PB);
    end
    // Matching word with valid low
    @(negedge clk);
    instValid = 0; instWord = good; #1;
    check("R11 flags idle", {126'd0, issueHit, issueMiss}, 128'd0);
    @(negedge clk);
    @(negedge clk);
    dbgRead(5'd12, d);
    check("R11 idle leaves register", d, PB);
  endtask

  task automatic testLatency();
    logic [127:0] d;
    for (int p = 0; p < 2; p++) begin
      dbgWrite(5'd4, p == 0 ? '1 : PA);
      dbgWrite(5'd5, p == 0 ? '0 : PB);
      dbgWrite(5'd6, 128'h77);
      issue(mkWord(1'b1, 2'b10, 5'd5, 5'd4, 5'd6));
      dbgRead(5'd6, d);
      check("R6 not written at accept edge", d, 128'h77);
      @(negedge clk);
      dbgRead(5'd6, d);
      check("R6 written one clock later",
            d, model(1'b1, 2'b10, p == 0 ? '1 : PA, p == 0 ? '0 : PB));
    end
  endtask

  task automatic testForward();
    logic [127:0] d, r1, r2;
    dbgWrite(5'd7, PA);
    dbgWrite(5'd8, PB);
    r1 = model(1'b1, 2'b00, PA, PB);
    r2 = model(1'b1, 2'b11, r1, r1);
    @(negedge clk);
    instValid = 1; instWord = mkWord(1'b1, 2'b00, 5'd8, 5'd7, 5'd9);
    @(negedge clk);
    instWord = mkWord(1'b1, 2'b11, 5'd9, 5'd9, 5'd11);
    @(negedge clk);
    instWord = mkWord(1'b1, 2'b01, 5'd8, 5'd11, 5'd13);
    @(negedge clk);
    instValid = 0;
    @(negedge clk);
    dbgRead(5'd11, d);
    check("R7 forward both sources", d, r2);
    dbgRead(5'd13, d);
    check("R7 forward first source", d, model(1'b1, 2'b01, r2, PB));
  endtask

  task automatic testAlias();
    logic [127:0] d;
    dbgWrite(5'd14, PA);
    issue(mkWord(1'b1, 2'b01, 5'd14, 5'd14, 5'd14));
    @(negedge clk);
    dbgRead(5'd14, d);
    check("R8 bit clear self", d, '0);
    dbgWrite(5'd15, PB);
    issue(mkWord(1'b0, 2'b11, 5'd15, 5'd15, 5'd15));
    @(negedge clk);
    dbgRead(5'd15, d);
    check("R8 orn self narrow", d, {64'd0, {64{1'b1}}});
  endtask

  task automatic testCollision();
    logic [127:0] d;
    dbgWrite(5'd16, PA);
    dbgWrite(5'd17, PB);
    // Same target: writeback beats debug write
    issue(mkWord(1'b1, 2'b10, 5'd17, 5'd16, 5'd18));
    dbgWrEn = 1; dbgWrIdx = 5'd18; dbgWrData = 128'hDEAD;
    @(negedge clk);
    dbgWrEn = 0;
    dbgRead(5'd18, d);
    check("R10 writeback wins", d, model(1'b1, 2'b10, PA, PB));
    // Different targets: both land
    issue(mkWord(1'b1, 2'b00, 5'd17, 5'd16, 5'd19));
    dbgWrEn = 1; dbgWrIdx = 5'd20; dbgWrData = 128'hBEEF;
    @(negedge clk);
    dbgWrEn = 0;
    dbgRead(5'd19, d);
    check("R10 writeback lands", d, model(1'b1, 2'b00, PA, PB));
    dbgRead(5'd20, d);
    check("R10 debug write lands", d, 128'hBEEF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; instValid = 0; instWord = '0;
    dbgWrEn = 0; dbgWrIdx = '0; dbgWrData = '0; dbgRdIdx = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testOps();
    testDecode();
    testLatency();
    testForward();
    testAlias();
    testCollision();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule